// File: doc/BRIEF.md
# I/O Access Splitter with Address Wraparound

This block sits between a processor's I/O request port and the downstream I/O fabric. It takes one request at a time: a 16-bit byte start address, a length of 1, 2 or 4 bytes, a read/write flag and up to four bytes of write data. It turns the request into one or two DWORD-aligned downstream transactions, each with a 17-bit address and a 4-bit byte enable. When the bytes of an access span two DWORDs, the access goes out as two transactions, lower DWORD first.

Addresses are formed with a carry into bit 16. An access that runs past byte FFFFh therefore reaches DWORD 10000h. This makes 64K+3 byte locations reachable. Every transaction, write or read, waits for its completion before the next step, because writes are non-posted.

For a split read, the bytes returned by the two completions are aligned back to the order of the access and delivered as one response. An error reported on either half marks the whole access as failed. Upstream requests use a valid/ready handshake. The block holds ready low from acceptance until its single-cycle response pulse has been given.

Top module: `io_split_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `dn_valid` is 0 and `rsp_valid` is 0.
- R2: An access whose bytes all fall in one DWORD is issued as exactly one transaction. Its `dn_addr` is the start address with bits 1:0 cleared and bit 16 at 0. `dn_be` bit i is set for lanes i = off .. off+len-1, where off is start address bits 1:0 and lane i is byte address `dn_addr`+i.
- R3: An access spanning two DWORDs is issued as two transactions. The first goes to the lower DWORD, with `dn_be` set from lane off through lane 3. The second goes to the next DWORD (lower address + 4), with lanes 0 upward set for the remaining bytes.
- R4: The address of the upper transaction is computed in 17 bits. A 4-byte access at FFFDh, FFFEh or FFFFh, or a 2-byte access at FFFFh, sends its upper transaction to 10000h with bit 16 set. A transaction with bit 16 set always has bits 15:0 equal to zero.
- R5: `dn_write` equals the request's write flag. Byte k of `req_wdata` (bits 8k+7:8k) appears on the lane that holds byte address start+k, in the transaction covering that byte.
- R6: Once a request is accepted, `req_ready` stays 0 until the cycle after its response pulse. No second request is accepted while one is outstanding.
- R7: The upper transaction of a split access is not presented on `dn_valid` until the completion of the lower one has been received.
- R8: A read response is a one-cycle `rsp_valid` pulse in the cycle after the last completion. `rsp_rdata` byte k holds the byte returned for address start+k, and bytes k >= len are zero. Completion lanes whose byte enable was clear are ignored.
- R9: `rsp_err` is 1 when `cpl_err` was 1 on the completion of either transaction of the access, and 0 otherwise.
- R10: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid`, `dn_addr`, `dn_be` and `dn_wdata` hold their values into the next cycle.
- R11: A write also ends with a one-cycle `rsp_valid` pulse in the cycle after its last completion, with `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Byte start address |
| req_len | input | 3 | Byte count: 1, 2 or 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| dn_valid | output | 1 | Downstream transaction present |
| dn_ready | input | 1 | Downstream accepts transaction |
| dn_addr | output | 17 | DWORD-aligned transaction address |
| dn_be | output | 4 | Byte-lane enables |
| dn_write | output | 1 | Transaction is a write |
| dn_wdata | output | 32 | Write data placed on lanes |
| cpl_valid | input | 1 | Completion for the issued transaction |
| cpl_rdata | input | 32 | Completion read data by lane |
| cpl_err | input | 1 | Completion carries an error |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read bytes aligned to the access |
| rsp_err | output | 1 | Access ended with an error |

## Verification
A transaction appears on `dn_valid` in the cycle after the request handshake edge, or in the cycle after the lower completion edge. The response pulse appears in the cycle after the final completion edge. `req_ready` returns one cycle after that. The bench drives every input at the falling edge and reads the ports at, or 1 ns after, the falling edge, so each value is taken in the middle of the cycle it belongs to. A scoreboard holds the expected transactions and responses in order, and the downstream model stalls `dn_ready` at random. While it delays each completion, the model also checks that nothing new is issued and that stalled transactions stay unchanged.

// File: rtl/io_split_pkg.sv
package io_split_pkg;
   typedef enum logic [1:0] {
      SPL_IDLE  = 2'd0,
      SPL_ISSUE = 2'd1,
      SPL_WAIT  = 2'd2,
      SPL_RESP  = 2'd3
   } spl_state_t;
endpackage

// File: rtl/io_split_decode.sv
// Turns a byte address and length into lower/upper DWORD addresses,
// lane enables and lane-aligned write data.
module io_split_decode #(
   parameter int ADDR_W = 16,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [$clog2(LANES):0]          len,
   input  logic [8*LANES-1:0]              wdata,
   output logic [ADDR_W:0]                 lo_addr,
   output logic [ADDR_W:0]                 hi_addr,
   output logic [LANES-1:0]                lo_be,
   output logic [LANES-1:0]                hi_be,
   output logic [16*LANES-1:0]             wide_wdata,
   output logic [$clog2(LANES)-1:0]        off
);
   localparam int OFF_W = $clog2(LANES);
   localparam int MW    = 2 * LANES;
   localparam int WW    = 16 * LANES;

   logic [MW-1:0] span;
   logic [MW-1:0] mask;

   always_comb begin
      off        = addr[OFF_W-1:0];
      span       = (MW'(1) << len) - MW'(1);
      mask       = span << off;
      lo_be      = mask[LANES-1:0];
      hi_be      = mask[MW-1:LANES];
      lo_addr    = {1'b0, addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      hi_addr    = lo_addr + (ADDR_W+1)'(LANES);
      wide_wdata = WW'(wdata) << (8 * off);
   end
endmodule

// File: rtl/io_split_merge.sv
// Collects enabled bytes of up to two completions and realigns them.
module io_split_merge #(
   parameter int LANES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       cap_valid,
   input  logic                       cap_upper,
   input  logic [LANES-1:0]           cap_be,
   input  logic [8*LANES-1:0]         cap_data,
   input  logic [$clog2(LANES)-1:0]   off,
   output logic [8*LANES-1:0]         rdata
);
   localparam int NB = 2 * LANES;

   logic [7:0]        line [NB];
   logic [8*NB-1:0]   line_flat;

   for (genvar j = 0; j < NB; j++) begin : g_byte
      localparam int  LN = j % LANES;
      localparam bit  UP = (j >= LANES);
      always_ff @(posedge clk) begin
         if (!rst_n || clear)
            line[j] <= '0;
         else if (cap_valid && (cap_upper == UP) && cap_be[LN])
            line[j] <= cap_data[8*LN +: 8];
      end
   end

   always_comb begin
      for (int j = 0; j < NB; j++) line_flat[8*j +: 8] = line[j];
      rdata = (8*LANES)'(line_flat >> (8 * off));
   end
endmodule

// File: rtl/io_split_unit.sv
module io_split_unit
   import io_split_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [$clog2(DATA_W/8):0]     req_len,
   input  logic                          req_write,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic                          dn_valid,
   input  logic                          dn_ready,
   output logic [ADDR_W:0]               dn_addr,
   output logic [DATA_W/8-1:0]           dn_be,
   output logic                          dn_write,
   output logic [DATA_W-1:0]             dn_wdata,
   input  logic                          cpl_valid,
   input  logic [DATA_W-1:0]             cpl_rdata,
   input  logic                          cpl_err,
   output logic                          rsp_valid,
   output logic [DATA_W-1:0]             rsp_rdata,
   output logic                          rsp_err
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int LEN_W = OFF_W + 1;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("io_split_unit: DATA_W must be a whole number of bytes");
   end
   if (LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_lanes
      $error("io_split_unit: lane count must be a power of two, at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("io_split_unit: ADDR_W too small for the lane count");
   end

   spl_state_t          st;
   logic [ADDR_W-1:0]   a_addr;
   logic [LEN_W-1:0]    a_len;
   logic                a_wr;
   logic [DATA_W-1:0]   a_wdata;
   logic                upper;
   logic                err_acc;

   logic [ADDR_W:0]     lo_addr, hi_addr;
   logic [LANES-1:0]    lo_be, hi_be;
   logic [2*DATA_W-1:0] wide_wdata;
   logic [OFF_W-1:0]    off;
   logic [DATA_W-1:0]   merged;
   logic                accept, split, last_cpl;

   io_split_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
      .addr(a_addr), .len(a_len), .wdata(a_wdata),
      .lo_addr(lo_addr), .hi_addr(hi_addr), .lo_be(lo_be), .hi_be(hi_be),
      .wide_wdata(wide_wdata), .off(off)
   );

   io_split_merge #(.LANES(LANES)) u_mrg (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .cap_valid(st == SPL_WAIT && cpl_valid && !a_wr),
      .cap_upper(upper), .cap_be(dn_be), .cap_data(cpl_rdata),
      .off(off), .rdata(merged)
   );

   assign req_ready = (st == SPL_IDLE);
   assign accept    = req_valid && req_ready;
   assign split     = |hi_be;
   assign last_cpl  = upper || !split;

   assign dn_valid  = (st == SPL_ISSUE);
   assign dn_addr   = upper ? hi_addr : lo_addr;
   assign dn_be     = upper ? hi_be : lo_be;
   assign dn_write  = a_wr;
   assign dn_wdata  = upper ? wide_wdata[2*DATA_W-1:DATA_W] : wide_wdata[DATA_W-1:0];

   assign rsp_valid = (st == SPL_RESP);
   assign rsp_rdata = a_wr ? '0 : merged;
   assign rsp_err   = err_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= SPL_IDLE;
         a_addr  <= '0;
         a_len   <= LEN_W'(1);
         a_wr    <= 1'b0;
         a_wdata <= '0;
         upper   <= 1'b0;
         err_acc <= 1'b0;
      end else begin
         unique case (st)
            SPL_IDLE: if (accept) begin
               a_addr  <= req_addr;
               a_len   <= req_len;
               a_wr    <= req_write;
               a_wdata <= req_wdata;
               upper   <= 1'b0;
               err_acc <= 1'b0;
               st      <= SPL_ISSUE;
            end
            SPL_ISSUE: if (dn_ready) st <= SPL_WAIT;
            SPL_WAIT: if (cpl_valid) begin
               err_acc <= err_acc | cpl_err;
               if (last_cpl) st <= SPL_RESP;
               else begin
                  upper <= 1'b1;
                  st    <= SPL_ISSUE;
               end
            end
            SPL_RESP: st <= SPL_IDLE;
            default:  st <= SPL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/io_split_chk.sv
module io_split_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic                      req_ready,
   input logic                      dn_valid,
   input logic                      dn_ready,
   input logic [ADDR_W:0]           dn_addr,
   input logic [DATA_W/8-1:0]       dn_be,
   input logic [DATA_W-1:0]         dn_wdata,
   input logic                      rsp_valid
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_addr[OFF_W-1:0] == '0);

   assert_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_be != '0);

   assert_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_addr[ADDR_W]) |-> dn_addr[ADDR_W-1:0] == '0);

   assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_no_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> !req_ready);

   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=>
         (dn_valid && $stable(dn_addr) && $stable(dn_be) && $stable(dn_wdata)));
endmodule

bind io_split_unit io_split_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_io_split_unit.sv
`timescale 1ns/100ps
module sim_io_split_unit;
   typedef struct {
      logic [16:0] addr;
      logic [3:0]  be;
      logic        wr;
      logic [31:0] wdata;
      logic        err;
      string       tag;
   } tx_t;
   typedef struct {
      logic [31:0] rdata;
      logic        err;
      logic        wr;
   } rsp_t;

   logic        clk = 0, rst_n = 0;
   logic        req_valid = 0, req_write = 0;
   logic [15:0] req_addr = '0;
   logic [2:0]  req_len = 3'd1;
   logic [31:0] req_wdata = '0;
   logic        req_ready, dn_valid, dn_write, rsp_valid, rsp_err;
   logic        dn_ready = 0, cpl_valid = 0, cpl_err = 0;
   logic [16:0] dn_addr;
   logic [3:0]  dn_be;
   logic [31:0] dn_wdata, rsp_rdata;
   logic [31:0] cpl_rdata = '0;

   int tests = 0, fails = 0, outstanding = 0;
   tx_t  tx_q[$];
   rsp_t rsp_q[$];

   always #2 clk = ~clk;

   io_split_unit u0 (.*);

   function automatic logic [7:0] pat(input logic [16:0] b);
      return b[7:0] + 8'(b[15:8] * 3) + (b[16] ? 8'h55 : 8'h00);
   endfunction

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] a, input int len, input logic wr,
                       input logic [31:0] wd, input logic e0, input logic e1);
      tx_t  t[2];
      rsp_t r;
      logic [16:0] first, b;
      bit   two = 0;
      first = {1'b0, a[15:2], 2'b00};
      for (int i = 0; i < 2; i++) begin
         t[i].addr = first + 17'(4*i); t[i].be = '0; t[i].wr = wr;
         t[i].wdata = '0; t[i].err = (i == 0) ? e0 : e1;
      end
      r.rdata = '0; r.wr = wr;
      for (int k = 0; k < len; k++) begin
         int idx;
         b   = {1'b0, a} + 17'(k);
         idx = ({b[16:2], 2'b00} != first) ? 1 : 0;
         if (idx == 1) two = 1;
         t[idx].be[b[1:0]] = 1'b1;
         t[idx].wdata[8*b[1:0] +: 8] = wd[8*k +: 8];
         if (!wr) r.rdata[8*k +: 8] = pat(b);
      end
      r.err = e0 | (two & e1);
      t[0].tag = two ? "R3" : "R2";
      t[1].tag = t[1].addr[16] ? "R4" : "R3";
      tx_q.push_back(t[0]);
      if (two) tx_q.push_back(t[1]);
      rsp_q.push_back(r);
      req_addr = a; req_len = 3'(len); req_write = wr; req_wdata = wd; req_valid = 1;
      forever begin
         logic s = req_ready;
         @(negedge clk);
         if (s) break;
      end
      req_valid = 0;
   endtask

   // downstream model: checks each transaction, then completes it late
   initial begin
      bit          stalled = 0;
      logic [16:0] h_addr; logic [3:0] h_be; logic [31:0] h_wd;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (stalled) begin
            chk("R10", "held valid", dn_valid, 1);
            chk("R10", "held addr/be/data", {dn_addr, dn_be, dn_wdata}, {h_addr, h_be, h_wd});
            stalled = 0;
         end
         dn_ready = ($urandom % 3) != 0;
         if (dn_valid && !dn_ready) begin
            stalled = 1; h_addr = dn_addr; h_be = dn_be; h_wd = dn_wdata;
         end else if (dn_valid && dn_ready) begin
            tx_t t;
            int  lat = 1 + ($urandom % 4);
            if (tx_q.size() == 0) begin
               chk("R2", "unexpected transaction", {dn_addr, dn_be}, '0);
               t.addr = dn_addr; t.err = 0; t.be = dn_be;
            end else begin
               t = tx_q.pop_front();
               chk(t.tag, "addr", dn_addr, t.addr);
               chk(t.tag, "be", dn_be, t.be);
               chk("R5", "write flag", dn_write, t.wr);
               if (t.wr)
                  for (int i = 0; i < 4; i++)
                     if (t.be[i]) chk("R5", "write lane", dn_wdata[8*i +: 8], t.wdata[8*i +: 8]);
            end
            @(negedge clk);
            dn_ready = 0;
            repeat (lat) begin
               if (dn_valid) chk("R7", "issued before completion", dn_valid, 0);
               @(negedge clk);
            end
            for (int i = 0; i < 4; i++) cpl_rdata[8*i +: 8] = pat(t.addr + 17'(i));
            cpl_err = t.err; cpl_valid = 1;
            @(negedge clk);
            cpl_valid = 0; cpl_err = 0; cpl_rdata = '0;
         end
      end
   end

   // response monitor and accept tracking
   initial begin
      forever begin
         @(negedge clk); #1;
         if (!rst_n) continue;
         if (rsp_valid) begin
            rsp_t r;
            if (rsp_q.size() == 0) chk("R8", "unexpected response", rsp_valid, 0);
            else begin
               r = rsp_q.pop_front();
               chk(r.wr ? "R11" : "R8", "rdata", rsp_rdata, r.rdata);
               chk("R9", "err", rsp_err, r.err);
               chk("R6", "ready low at response", req_ready, 0);
            end
            outstanding--;
         end
         if (req_valid && req_ready) begin
            if (outstanding != 0) chk("R6", "accept while busy", outstanding, 0);
            outstanding++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R6 watchdog: pending %0d expected 0", rsp_q.size());
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "ready in reset", req_ready, 1);
      chk("R1", "dn_valid in reset", dn_valid, 0);
      chk("R1", "rsp_valid in reset", rsp_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "outputs after reset", {req_ready, dn_valid, rsp_valid}, 3'b100);
      // single DWORD reads, all offsets and sizes
      for (int o = 0; o < 4; o++) send(16'h1230 + 16'(o), 1, 0, 0, 0, 0);
      send(16'h2001, 2, 0, 0, 0, 0);
      send(16'h3000, 4, 0, 0, 0, 0);
      // crossing reads and writes
      send(16'h2003, 2, 0, 0, 0, 0);
      for (int o = 1; o < 4; o++) send(16'h4000 + 16'(o), 4, 0, 0, 0, 0);
      send(16'h5002, 4, 1, 32'hA1B2C3D4, 0, 0);
      send(16'h5003, 2, 1, 32'h0000BEEF, 0, 0);
      send(16'h5001, 2, 1, 32'h00001234, 0, 0);
      // wraparound into bit 16
      send(16'hFFFD, 4, 0, 0, 0, 0);
      send(16'hFFFE, 4, 0, 0, 0, 0);
      send(16'hFFFF, 4, 1, 32'hCAFEF00D, 0, 0);
      send(16'hFFFF, 2, 0, 0, 0, 0);
      send(16'hFFFE, 2, 0, 0, 0, 0);
      send(16'hFFFF, 1, 1, 32'h0000005A, 0, 0);
      // error merging
      send(16'h6003, 2, 0, 0, 1, 0);
      send(16'h6003, 2, 0, 0, 0, 1);
      send(16'h6002, 4, 1, 32'h11223344, 0, 1);
      send(16'h6000, 4, 0, 0, 1, 0);
      // random mix
      for (int n = 0; n < 60; n++) begin
         logic [15:0] a = 16'($urandom);
         int lens[3] = '{1, 2, 4};
         if ($urandom % 4 == 0) a = 16'hFFFC + 16'($urandom % 4);
         send(a, lens[$urandom % 3], 1'($urandom), $urandom, 1'($urandom % 7 == 0), 1'($urandom % 7 == 0));
      end
      wait (tx_q.size() == 0 && rsp_q.size() == 0 && outstanding == 0);
      repeat (5) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule